// File: doc/BRIEF.md
# Parallel-Port Bus Controller with Handshake Timeout

This block is the controller side of an 8-bit, byte-wide parallel handshake bus. Host logic hands it a single bus operation through a valid/ready command port. Each command chooses an address cycle or a data cycle, and a read or a write. The block drives the write-enable line and the bus data with its output enable. It then lowers one of two active-low strobes and waits for the peripheral to raise its wait line as an acknowledge. When the peripheral returns wait to low, the block issues a one-cycle response that carries the read data, or an error flag if the acknowledge never came.

The peripheral's wait line passes through a configurable synchronizer. A settle delay of a programmable number of clocks separates the setup of write-enable and data from the strobe edge. The handshake limit is written in nanoseconds. The block clamps the requested value to its supported window, rounds it to the nearest 1024 ns step, and reports the value it applied. It turns that value into a clock-cycle limit by dividing by the clock period parameter. The same limit bounds both the wait for the acknowledge and the wait for the wait line to fall again.

Top module: `ppbus_ctrl`

## Requirements
- R1: After reset, both strobes and write-enable are high, the output enable is low, no response is pending, and the applied timeout reads TMO_DEF_NS (10240 ns by default).
- R2: cmd_ready is high only while no operation is in progress and the synchronized wait line is 0. A command is accepted on a clock edge where cmd_valid and cmd_ready are both high.
- R3: cmd_addr_sel=1 selects the address strobe (bus_astb_n) and cmd_addr_sel=0 selects the data strobe (bus_dstb_n). The two strobes are never low at the same time.
- R4: For a write (cmd_read=0), bus_wr_n is 0 and bus_oe is 1 with bus_dout equal to cmd_wdata, from the cycle after acceptance until the strobe rises. For a read, bus_wr_n stays 1 and bus_oe stays 0.
- R5: The strobe falls after exactly SETTLE (default 2) clock cycles of setup that follow the accepting edge.
- R6: bus_wr_n and bus_dout do not change while a strobe is low.
- R7: When the synchronized wait line reads 1 during the strobe, a read captures bus_din and the strobe rises. The following response carries that byte with rsp_timeout=0. rsp_valid lasts a single cycle.
- R8: If no acknowledge has been seen after the strobe has been low for the cycle limit, the strobe rises, the bus is released and the response has rsp_timeout=1. An acknowledge seen in the last low cycle still counts as success.
- R9: After the strobe rises, the response and the next cmd_ready wait until the synchronized wait line is 0 again. This wait is bounded by the same cycle limit, and the response flags an error if the limit expires.
- R10: A pulse on cfg_valid sets the timeout. Requests below 5120 ns clamp to 5120 ns and requests above 261120 ns clamp to 261120 ns. Other values round to the nearest multiple of 1024 ns, with ties rounding up. cfg_applied_ns shows the result from the next cycle.
- R11: The cycle limit equals cfg_applied_ns divided by CLK_NS (640 cycles for 5120 ns at 8 ns).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Load a new timeout request |
| cfg_ns | input | 32 | Requested timeout in ns |
| cfg_applied_ns | output | 32 | Timeout in effect, in ns |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_addr_sel | input | 1 | 1 = address cycle, 0 = data cycle |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_wdata | input | DW | Write byte |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DW | Read byte (0 on error) |
| rsp_timeout | output | 1 | Handshake timed out |
| bus_wr_n | output | 1 | Active-low write enable |
| bus_oe | output | 1 | Drive enable for bus_dout |
| bus_dout | output | DW | Data driven onto the bus |
| bus_din | input | DW | Data read from the bus |
| bus_astb_n | output | 1 | Active-low address strobe |
| bus_dstb_n | output | 1 | Active-low data strobe |
| bus_wait | input | 1 | Peripheral acknowledge/busy line |

## Verification
The acknowledge and the timeout expiry can land in the same strobe cycle. In that case the acknowledge must win. The bench sets the limit to 640 cycles and raises the wait line at strobe-low cycle 637. The two synchronizer stages make the acknowledge visible in cycle 639, the last counted cycle, and the response must carry no error. Raising the wait line one cycle later must produce an error. In both runs the strobe must have stayed low for exactly 640 cycles.

// File: rtl/ppbus_pkg.sv
package ppbus_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_SETUP   = 2'd1,
      ST_STROBE  = 2'd2,
      ST_RELEASE = 2'd3
   } ppbus_state_e;
endpackage

// File: rtl/ppbus_sync.sv
module ppbus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '0;
            else if (STAGES == 1) sr <= d;
            else sr <= {sr[STAGES-2:0], d};
         end
         assign q = sr[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/ppbus_tmo_cfg.sv
module ppbus_tmo_cfg #(
   parameter int CLK_NS     = 8,
   parameter int MIN_NS     = 5120,
   parameter int MAX_NS     = 261120,
   parameter int STEP_LOG2  = 10,
   parameter int DEF_NS     = 10240,
   parameter int CW         = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_valid,
   input  logic [31:0]   cfg_ns,
   output logic [31:0]   applied_ns,
   output logic [CW-1:0] lim_cyc
);
   localparam logic [31:0] MIN_V  = 32'(MIN_NS);
   localparam logic [31:0] MAX_V  = 32'(MAX_NS);
   localparam logic [31:0] HALF_V = 32'(1) << (STEP_LOG2 - 1);
   localparam logic [31:0] CLK_V  = 32'(CLK_NS);
   localparam logic [31:0] DEF_V  = 32'(DEF_NS);
   localparam logic [31:0] DEF_L  = DEF_V / CLK_V;

   logic [31:0] clamped, rounded, lim_full;

   always_comb begin
      if (cfg_ns < MIN_V)      clamped = MIN_V;
      else if (cfg_ns > MAX_V) clamped = MAX_V;
      else                     clamped = cfg_ns;
      rounded  = ((clamped + HALF_V) >> STEP_LOG2) << STEP_LOG2;
      lim_full = rounded / CLK_V;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         applied_ns <= DEF_V;
         lim_cyc    <= DEF_L[CW-1:0];
      end else if (cfg_valid) begin
         applied_ns <= rounded;
         lim_cyc    <= lim_full[CW-1:0];
      end
   end
endmodule

// File: rtl/ppbus_seq.sv
module ppbus_seq
   import ppbus_pkg::*;
#(
   parameter int DW     = 8,
   parameter int CW     = 15,
   parameter int SETTLE = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   output logic          cmd_ready,
   input  logic          cmd_addr_sel,
   input  logic          cmd_read,
   input  logic [DW-1:0] cmd_wdata,
   input  logic          wait_s,
   input  logic [DW-1:0] bus_din,
   input  logic [CW-1:0] lim_cyc,
   output logic          bus_wr_n,
   output logic          bus_oe,
   output logic [DW-1:0] bus_dout,
   output logic          bus_astb_n,
   output logic          bus_dstb_n,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata,
   output logic          rsp_timeout
);
   localparam logic [CW-1:0] SETTLE_LAST = (SETTLE > 0) ? CW'(SETTLE - 1) : '0;

   ppbus_state_e  state;
   logic [CW-1:0] cnt;
   logic          op_addr, op_rd, tmo_flag;
   logic [DW-1:0] wbuf, rbuf;
   logic          at_limit, driving;

   assign at_limit   = (cnt >= lim_cyc - CW'(1));
   assign driving    = !op_rd && (state == ST_SETUP || state == ST_STROBE);
   assign cmd_ready  = (state == ST_IDLE) && !wait_s;
   assign bus_astb_n = !((state == ST_STROBE) && op_addr);
   assign bus_dstb_n = !((state == ST_STROBE) && !op_addr);
   assign bus_wr_n   = !driving;
   assign bus_oe     = driving;
   assign bus_dout   = wbuf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         cnt         <= '0;
         op_addr     <= 1'b0;
         op_rd       <= 1'b1;
         tmo_flag    <= 1'b0;
         wbuf        <= '0;
         rbuf        <= '0;
         rsp_valid   <= 1'b0;
         rsp_rdata   <= '0;
         rsp_timeout <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (cmd_valid && cmd_ready) begin
                  op_addr  <= cmd_addr_sel;
                  op_rd    <= cmd_read;
                  wbuf     <= cmd_read ? '0 : cmd_wdata;
                  tmo_flag <= 1'b0;
                  rbuf     <= '0;
                  cnt      <= '0;
                  state    <= (SETTLE == 0) ? ST_STROBE : ST_SETUP;
               end
            end
            ST_SETUP: begin
               if (cnt == SETTLE_LAST) begin
                  cnt   <= '0;
                  state <= ST_STROBE;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            ST_STROBE: begin
               if (wait_s) begin
                  if (op_rd) rbuf <= bus_din;
                  cnt   <= '0;
                  state <= ST_RELEASE;
               end else if (at_limit) begin
                  tmo_flag <= 1'b1;
                  cnt      <= '0;
                  state    <= ST_RELEASE;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            ST_RELEASE: begin
               if (!wait_s || at_limit) begin
                  rsp_valid   <= 1'b1;
                  rsp_timeout <= tmo_flag || wait_s;
                  rsp_rdata   <= (tmo_flag || wait_s) ? '0 : rbuf;
                  cnt         <= '0;
                  state       <= ST_IDLE;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ppbus_ctrl.sv
module ppbus_ctrl #(
   parameter int DW            = 8,
   parameter int CLK_NS        = 8,
   parameter int SETTLE        = 2,
   parameter int SYNC_STAGES   = 2,
   parameter int TMO_MIN_NS    = 5120,
   parameter int TMO_MAX_NS    = 261120,
   parameter int TMO_STEP_LOG2 = 10,
   parameter int TMO_DEF_NS    = 10240
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_valid,
   input  logic [31:0]   cfg_ns,
   output logic [31:0]   cfg_applied_ns,
   input  logic          cmd_valid,
   output logic          cmd_ready,
   input  logic          cmd_addr_sel,
   input  logic          cmd_read,
   input  logic [DW-1:0] cmd_wdata,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata,
   output logic          rsp_timeout,
   output logic          bus_wr_n,
   output logic          bus_oe,
   output logic [DW-1:0] bus_dout,
   input  logic [DW-1:0] bus_din,
   output logic          bus_astb_n,
   output logic          bus_dstb_n,
   input  logic          bus_wait
);
   localparam int CW       = $clog2(TMO_MAX_NS / CLK_NS + 1);
   localparam int STEP_NS  = 1 << TMO_STEP_LOG2;

   generate
      if (CLK_NS < 1 || TMO_MIN_NS / CLK_NS < 4) begin : g_bad_clk
         $error("ppbus_ctrl: CLK_NS must be positive and give at least 4 limit cycles");
      end
      if (TMO_MIN_NS % STEP_NS != 0 || TMO_MAX_NS % STEP_NS != 0 ||
          TMO_MIN_NS > TMO_MAX_NS) begin : g_bad_range
         $error("ppbus_ctrl: timeout window must be step aligned and ordered");
      end
      if (TMO_DEF_NS % STEP_NS != 0 || TMO_DEF_NS < TMO_MIN_NS ||
          TMO_DEF_NS > TMO_MAX_NS) begin : g_bad_def
         $error("ppbus_ctrl: default timeout must be an in-range step");
      end
      if (SETTLE < 0 || SETTLE >= TMO_MIN_NS / CLK_NS) begin : g_bad_settle
         $error("ppbus_ctrl: SETTLE out of range");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("ppbus_ctrl: SYNC_STAGES must be 0..4");
      end
   endgenerate

   logic          wait_s;
   logic [CW-1:0] lim_cyc;

   ppbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(bus_wait), .q(wait_s)
   );

   ppbus_tmo_cfg #(
      .CLK_NS(CLK_NS), .MIN_NS(TMO_MIN_NS), .MAX_NS(TMO_MAX_NS),
      .STEP_LOG2(TMO_STEP_LOG2), .DEF_NS(TMO_DEF_NS), .CW(CW)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ns(cfg_ns),
      .applied_ns(cfg_applied_ns), .lim_cyc(lim_cyc)
   );

   ppbus_seq #(.DW(DW), .CW(CW), .SETTLE(SETTLE)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_addr_sel(cmd_addr_sel), .cmd_read(cmd_read), .cmd_wdata(cmd_wdata),
      .wait_s(wait_s), .bus_din(bus_din), .lim_cyc(lim_cyc),
      .bus_wr_n(bus_wr_n), .bus_oe(bus_oe), .bus_dout(bus_dout),
      .bus_astb_n(bus_astb_n), .bus_dstb_n(bus_dstb_n),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout)
   );
endmodule

// File: rtl/ppbus_ctrl_chk.sv
module ppbus_ctrl_chk #(
   parameter int DW     = 8,
   parameter int CW     = 15,
   parameter int CLK_NS = 8,
   parameter int MIN_NS = 5120,
   parameter int MAX_NS = 261120
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_ready,
   input logic          rsp_valid,
   input logic          bus_wr_n,
   input logic          bus_oe,
   input logic [DW-1:0] bus_dout,
   input logic          bus_astb_n,
   input logic          bus_dstb_n,
   input logic [31:0]   cfg_applied_ns,
   input logic [CW-1:0] lim_cyc
);
   logic        strobe_low;
   logic [31:0] win;
   logic [CW-1:0] lim_q;
   logic        skip;

   assign strobe_low = !bus_astb_n || !bus_dstb_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win   <= '0;
         lim_q <= lim_cyc;
         skip  <= 1'b0;
      end else begin
         lim_q <= lim_cyc;
         if (strobe_low) begin
            win <= win + 32'd1;
            if (lim_cyc != lim_q) skip <= 1'b1;
         end else begin
            win  <= '0;
            skip <= 1'b0;
         end
      end
   end

   assert_ready_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> (bus_astb_n && bus_dstb_n && !bus_oe));

   assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(!bus_astb_n && !bus_dstb_n));

   assert_drive_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_low && !bus_wr_n) |-> bus_oe);

   assert_hold_while_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_low && $past(strobe_low)) |-> ($stable(bus_wr_n) && $stable(bus_dout)));

   assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_strobe_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_low && !skip && lim_cyc == lim_q) |-> (win < {{(32-CW){1'b0}}, lim_cyc}));

   assert_applied_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_applied_ns >= 32'(MIN_NS)) && (cfg_applied_ns <= 32'(MAX_NS)) &&
      (cfg_applied_ns[9:0] == 10'd0));

   assert_limit_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ({{(32-CW){1'b0}}, lim_cyc} * 32'(CLK_NS)) == cfg_applied_ns);
endmodule

bind ppbus_ctrl ppbus_ctrl_chk #(
   .DW(DW), .CW(CW), .CLK_NS(CLK_NS), .MIN_NS(TMO_MIN_NS), .MAX_NS(TMO_MAX_NS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
   .bus_wr_n(bus_wr_n), .bus_oe(bus_oe), .bus_dout(bus_dout),
   .bus_astb_n(bus_astb_n), .bus_dstb_n(bus_dstb_n),
   .cfg_applied_ns(cfg_applied_ns), .lim_cyc(lim_cyc)
);

// File: tb/sim_ppbus_ctrl.sv
module sim_ppbus_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_valid = 1'b0;
   logic [31:0] cfg_ns = '0;
   logic [31:0] cfg_applied_ns;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic        cmd_addr_sel = 1'b0;
   logic        cmd_read = 1'b0;
   logic [7:0]  cmd_wdata = '0;
   logic        rsp_valid;
   logic [7:0]  rsp_rdata;
   logic        rsp_timeout;
   logic        bus_wr_n, bus_oe;
   logic [7:0]  bus_dout;
   logic [7:0]  bus_din = '0;
   logic        bus_astb_n, bus_dstb_n;
   logic        bus_wait = 1'b0;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   ppbus_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ns(cfg_ns),
      .cfg_applied_ns(cfg_applied_ns), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_addr_sel(cmd_addr_sel), .cmd_read(cmd_read), .cmd_wdata(cmd_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout),
      .bus_wr_n(bus_wr_n), .bus_oe(bus_oe), .bus_dout(bus_dout), .bus_din(bus_din),
      .bus_astb_n(bus_astb_n), .bus_dstb_n(bus_dstb_n), .bus_wait(bus_wait)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // addr_sel, read, wdata, peripheral byte
   localparam logic [17:0] VEC [6] = '{
      {1'b1, 1'b0, 8'hA5, 8'h00},
      {1'b0, 1'b0, 8'h3C, 8'h00},
      {1'b1, 1'b1, 8'h00, 8'h5A},
      {1'b0, 1'b1, 8'h00, 8'hC3},
      {1'b0, 1'b0, 8'hFF, 8'h00},
      {1'b1, 1'b1, 8'h00, 8'h01}
   };

   task automatic set_cfg(input logic [31:0] ns, input logic [31:0] exp);
      @(negedge clk);
      cfg_ns = ns; cfg_valid = 1'b1;
      @(negedge clk);
      cfg_valid = 1'b0;
      chk(cfg_applied_ns == exp, "R10 applied timeout", cfg_applied_ns, exp);
   endtask

   // ack_at < 0: peripheral never acknowledges
   task automatic run_op(input bit a, input bit rd, input logic [7:0] wd,
                         input logic [7:0] pd, input int ack_at, input int hold,
                         output int slen, output bit tmo, output logic [7:0] rdat,
                         output int settle, output bit saw_a, output bit saw_d,
                         output bit hold_ok, output bit early_rsp);
      int k;
      logic w0;
      logic [7:0] d0;
      @(negedge clk);
      cmd_addr_sel = a; cmd_read = rd; cmd_wdata = wd; cmd_valid = 1'b1;
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      settle = 0;
      hold_ok = 1'b1;
      while (bus_astb_n && bus_dstb_n && settle < 50) begin
         if (bus_wr_n != rd || bus_oe != !rd || (!rd && bus_dout != wd)) hold_ok = 1'b0;
         settle++;
         @(negedge clk);
      end
      saw_a = !bus_astb_n; saw_d = !bus_dstb_n;
      w0 = bus_wr_n; d0 = bus_dout;
      k = 0;
      while ((!bus_astb_n || !bus_dstb_n) && k < 100000) begin
         if (bus_wr_n != w0 || bus_dout != d0 || bus_wr_n != rd) hold_ok = 1'b0;
         if (k == ack_at) begin bus_din = pd; bus_wait = 1'b1; end
         k++;
         @(negedge clk);
      end
      slen = k;
      early_rsp = 1'b0;
      if (ack_at >= 0) begin
         for (int h = 0; h < hold; h++) begin
            if (rsp_valid || cmd_ready) early_rsp = 1'b1;
            @(negedge clk);
         end
         bus_wait = 1'b0;
      end
      k = 0;
      while (!rsp_valid && k < 100000) begin k++; @(negedge clk); end
      tmo = rsp_timeout; rdat = rsp_rdata;
      bus_din = '0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual 1 expected 0");
         finish_run();
      end
   end

   initial begin
      int slen, settle;
      bit tmo, sa, sd, hok, er;
      logic [7:0] rdat;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(bus_astb_n && bus_dstb_n, "R1 strobes high", {bus_astb_n, bus_dstb_n}, 3);
      chk(bus_wr_n == 1'b1 && bus_oe == 1'b0, "R1 wr_n/oe idle", {bus_wr_n, bus_oe}, 2);
      chk(rsp_valid == 1'b0, "R1 no response", rsp_valid, 0);
      chk(cfg_applied_ns == 32'd10240, "R1 default timeout", cfg_applied_ns, 10240);
      chk(cmd_ready == 1'b1, "R2 ready when idle", cmd_ready, 1);

      // R2: busy wait line blocks acceptance
      bus_wait = 1'b1;
      repeat (3) @(negedge clk);
      chk(cmd_ready == 1'b0, "R2 ready low while wait high", cmd_ready, 0);
      bus_wait = 1'b0;
      repeat (3) @(negedge clk);
      chk(cmd_ready == 1'b1, "R2 ready back", cmd_ready, 1);

      // vector table: R3 R4 R5 R6 R7 R9
      foreach (VEC[i]) begin
         run_op(VEC[i][17], VEC[i][16], VEC[i][15:8], VEC[i][7:0], 3, 5,
                slen, tmo, rdat, settle, sa, sd, hok, er);
         chk(sa == VEC[i][17] && sd == !VEC[i][17], "R3 strobe select",
             {sa, sd}, {VEC[i][17], !VEC[i][17]});
         chk(settle == 2, "R5 settle cycles", settle, 2);
         chk(hok, "R4 R6 wr_n/data drive and hold", hok, 1);
         chk(!er, "R9 response waits for wait low", er, 0);
         chk(tmo == 1'b0, "R7 no timeout on ack", tmo, 0);
         if (VEC[i][16]) chk(rdat == VEC[i][7:0], "R7 read data", rdat, VEC[i][7:0]);
      end

      // R10 quantizer corners
      set_cfg(32'd0, 32'd5120);
      set_cfg(32'd300000, 32'd261120);
      set_cfg(32'd6655, 32'd6144);
      set_cfg(32'd6656, 32'd7168);
      set_cfg(32'd261120, 32'd261120);
      set_cfg(32'd5120, 32'd5120);

      // R8 R11: ack visible in last limit cycle (640) wins
      run_op(1'b0, 1'b1, 8'h00, 8'h77, 637, 2, slen, tmo, rdat, settle, sa, sd, hok, er);
      chk(slen == 640, "R8 R11 strobe length with late ack", slen, 640);
      chk(tmo == 1'b0, "R8 ack on last cycle succeeds", tmo, 0);
      chk(rdat == 8'h77, "R7 late ack data", rdat, 8'h77);

      // one cycle too late -> timeout
      run_op(1'b1, 1'b0, 8'h11, 8'h00, 638, 2, slen, tmo, rdat, settle, sa, sd, hok, er);
      chk(slen == 640, "R8 strobe length at expiry", slen, 640);
      chk(tmo == 1'b1, "R8 ack after limit times out", tmo, 1);

      // no ack at default limit 10240 ns -> 1280 cycles
      set_cfg(32'd10240, 32'd10240);
      run_op(1'b0, 1'b1, 8'h00, 8'h00, -1, 0, slen, tmo, rdat, settle, sa, sd, hok, er);
      chk(slen == 1280, "R11 limit from applied ns", slen, 1280);
      chk(tmo == 1'b1 && rdat == 8'h00, "R8 timeout flag and data", {tmo, rdat}, 9'h100);
      chk(bus_oe == 1'b0 && bus_wr_n == 1'b1, "R8 bus released", {bus_oe, bus_wr_n}, 1);

      // R9: wait stuck high after ack -> release phase times out
      set_cfg(32'd5120, 32'd5120);
      run_op(1'b0, 1'b1, 8'h00, 8'h42, 2, 700, slen, tmo, rdat, settle, sa, sd, hok, er);
      chk(er == 1'b1, "R9 stuck wait ends release phase", er, 1);
      chk(tmo == 1'b1, "R9 release timeout flagged", tmo, 1);

      done = 1;
      finish_run();
   end
endmodule